// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block derives horizontal and vertical raster timing for a display pipe from a set of boundary registers loaded through a simple write port. A pixel counter runs across each line and a line counter steps once per line. Comparisons against the loaded boundaries give horizontal and vertical sync pulses, the active-picture window, and a one-pixel strobe that tells the pixel fetch logic to start loading the next line early.

Every boundary register holds its position minus one, so a line of N pixels is programmed as N-1. Sync outputs pass through a conditioning stage that can invert each pulse, suppress each pulse, suppress both together, and flag composite sync for a sync-on-green output. A separate blanking control turns the picture off while sync keeps running, which is how the display is put into a power-saving state. Timing boundaries are double-buffered: while the generator runs, new values wait for the next frame start, so a mode change never produces a torn frame.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset both counters read 0, `de_o` and `prefetch_o` are low, `blank_o` is high, and `hsync_o`, `vsync_o` and `csync_o` are low.
- R2: While the enable bit (bit 0 of the control register at address 0) is clear, both counters are held at 0 and no sync pulse, display window or prefetch strobe is produced.
- R3: While enabled, the pixel counter counts up by one per clock and returns to 0 on the clock after it equals the line-total register (address 4, value total-1); the line counter advances only on that return and itself returns to 0 after equalling the frame-total register (address 8).
- R4: `de_o` is high exactly when the generator is enabled, the refresh bit (bit 1 of address 0) is set, the display is not forced off, the pixel count is at or below the active-width register (address 5) and the line count is at or below the active-height register (address 9); `blank_o` is its complement.
- R5: The unconditioned horizontal pulse is active for pixel counts from the hsync-start register (address 6) up to, but not including, the hsync-end register (address 7); the vertical pulse likewise uses lines from address 10 up to but not including address 11.
- R6: In the sync control register (address 1), bit 3 inverts `hsync_o` and bit 4 inverts `vsync_o`.
- R7: In the sync control register, bit 5 suppresses the horizontal pulse, bit 6 suppresses the vertical pulse, and bit 1 suppresses both; a suppressed output rests at its inversion level.
- R8: When bit 0 of the sync control register is set, `csync_o` is high whenever either unsuppressed pulse is active; otherwise it is low.
- R9: Bit 1 of the display control register (address 2) forces `de_o` low and `blank_o` high while the sync outputs continue unchanged.
- R10: `prefetch_o` pulses for one pixel per line when the pixel count equals the prefetch register (address 12), clamped to the line-total value if larger, while enabled with refresh set.
- R11: Timing registers (addresses 4 to 12) written while enabled take effect at the next frame start (the clock on which both counters return to 0); while disabled they take effect on the next clock. Addresses 0 to 2 take effect on the next clock in every case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | CNT_W (12) | Register write data |
| hsync_o | output | 1 | Conditioned horizontal sync |
| vsync_o | output | 1 | Conditioned vertical sync |
| csync_o | output | 1 | Composite sync flag for sync-on-green |
| de_o | output | 1 | Display enable (active picture) |
| blank_o | output | 1 | Blank flag |
| hcount_o | output | CNT_W (12) | Pixel counter |
| vcount_o | output | CNT_W (12) | Line counter |
| prefetch_o | output | 1 | Early line-fetch strobe |

## Verification
The hardest case to reach is a timing write landing in the middle of a running frame, where the design must keep the old boundaries until the counters both wrap and then switch cleanly. The stimulus enables a small mode, waits into the frame, rewrites the line total and active width, and runs across the frame boundary while a behavioural model holding separate pending and live copies predicts every output on every clock. A prefetch value above the line total, disable in mid-line, and each sync-control bit alone are also driven so that the clamp, counter clearing and each conditioning path are observed.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_SYNC = 4'd1;
  localparam logic [ADDR_W-1:0] A_DISP = 4'd2;
  localparam logic [ADDR_W-1:0] A_TIM0 = 4'd4;

  typedef enum int {
    T_HTOT = 0,
    T_HACT = 1,
    T_HSS  = 2,
    T_HSE  = 3,
    T_VTOT = 4,
    T_VACT = 5,
    T_VSS  = 6,
    T_VSE  = 7,
    T_PF   = 8
  } tim_idx_e;

  localparam int NUM_TIM = 9;

  // control register bits
  localparam int B_EN      = 0;
  localparam int B_REFRESH = 1;
  // sync control bits
  localparam int B_SOG     = 0;
  localparam int B_ALLOFF  = 1;
  localparam int B_HINV    = 3;
  localparam int B_VINV    = 4;
  localparam int B_HOFF    = 5;
  localparam int B_VOFF    = 6;
  // display control bit
  localparam int B_DOFF    = 1;

  typedef struct packed {
    logic sog;
    logic all_off;
    logic hinv;
    logic vinv;
    logic hoff;
    logic voff;
  } sync_ctl_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [CNT_W-1:0]                 wr_data_i,
  input  logic                             frame_wrap_i,
  output logic                             en_o,
  output logic                             refresh_o,
  output logic                             disp_off_o,
  output sync_ctl_t                        sync_o,
  output logic [NUM_TIM-1:0][CNT_W-1:0]    tim_o
);
  logic                          en_q, refresh_q, disp_off_q;
  sync_ctl_t                     sync_q;
  logic [NUM_TIM-1:0][CNT_W-1:0] shadow_q;
  logic [NUM_TIM-1:0][CNT_W-1:0] live_q;
  logic                          commit;

  assign commit = ~en_q | frame_wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      refresh_q  <= 1'b0;
      disp_off_q <= 1'b0;
      sync_q     <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL) begin
        en_q      <= wr_data_i[B_EN];
        refresh_q <= wr_data_i[B_REFRESH];
      end
      if (wr_addr_i == A_SYNC) begin
        sync_q.sog     <= wr_data_i[B_SOG];
        sync_q.all_off <= wr_data_i[B_ALLOFF];
        sync_q.hinv    <= wr_data_i[B_HINV];
        sync_q.vinv    <= wr_data_i[B_VINV];
        sync_q.hoff    <= wr_data_i[B_HOFF];
        sync_q.voff    <= wr_data_i[B_VOFF];
      end
      if (wr_addr_i == A_DISP) begin
        disp_off_q <= wr_data_i[B_DOFF];
      end
    end
  end

  for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
    localparam logic [ADDR_W-1:0] ADDR = A_TIM0 + ADDR_W'(i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[i] <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR) begin
        shadow_q[i] <= wr_data_i;
      end
    end

    // live copy follows the pending copy only at frame start or while idle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        live_q[i] <= '0;
      end else if (commit) begin
        live_q[i] <= shadow_q[i];
      end
    end
  end

  assign en_o       = en_q;
  assign refresh_o  = refresh_q;
  assign disp_off_o = disp_off_q;
  assign sync_o     = sync_q;
  assign tim_o      = live_q;
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] htot_i,
  input  logic [CNT_W-1:0] vtot_i,
  output logic [CNT_W-1:0] hcnt_o,
  output logic [CNT_W-1:0] vcnt_o,
  output logic             frame_wrap_o
);
  logic [CNT_W-1:0] h_q, v_q;
  logic             line_end, last_line;

  assign line_end     = (h_q == htot_i);
  assign last_line    = (v_q == vtot_i);
  assign frame_wrap_o = en_i & line_end & last_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (!en_i) begin
      h_q <= '0;
      v_q <= '0;
    end else if (line_end) begin
      h_q <= '0;
      v_q <= last_line ? '0 : v_q + CNT_W'(1);
    end else begin
      h_q <= h_q + CNT_W'(1);
    end
  end

  assign hcnt_o = h_q;
  assign vcnt_o = v_q;
endmodule

// File: rtl/dtg_pulse_cond.sv
module dtg_pulse_cond #(
  parameter int CNT_W = 12
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] stop_i,
  input  logic             off_i,
  input  logic             inv_i,
  output logic             gated_o,
  output logic             pin_o
);
  logic raw;

  // half-open window: start inclusive, stop exclusive
  assign raw     = en_i & (cnt_i >= start_i) & (cnt_i < stop_i);
  assign gated_o = raw & ~off_i;
  assign pin_o   = gated_o ^ inv_i;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [3:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             csync_o,
  output logic             de_o,
  output logic             blank_o,
  output logic [CNT_W-1:0] hcount_o,
  output logic [CNT_W-1:0] vcount_o,
  output logic             prefetch_o
);
  logic                          ctrl_en, ctrl_refresh, disp_off, frame_wrap;
  sync_ctl_t                     sync_ctl;
  logic [NUM_TIM-1:0][CNT_W-1:0] tim_act;
  logic [CNT_W-1:0]              hcnt, vcnt, pf_eff;
  logic                          h_gated, v_gated, in_window;

  dtg_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .frame_wrap_i (frame_wrap),
    .en_o         (ctrl_en),
    .refresh_o    (ctrl_refresh),
    .disp_off_o   (disp_off),
    .sync_o       (sync_ctl),
    .tim_o        (tim_act)
  );

  dtg_counters #(.CNT_W(CNT_W)) i_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ctrl_en),
    .htot_i       (tim_act[T_HTOT]),
    .vtot_i       (tim_act[T_VTOT]),
    .hcnt_o       (hcnt),
    .vcnt_o       (vcnt),
    .frame_wrap_o (frame_wrap)
  );

  dtg_pulse_cond #(.CNT_W(CNT_W)) i_hs (
    .en_i    (ctrl_en),
    .cnt_i   (hcnt),
    .start_i (tim_act[T_HSS]),
    .stop_i  (tim_act[T_HSE]),
    .off_i   (sync_ctl.hoff | sync_ctl.all_off),
    .inv_i   (sync_ctl.hinv),
    .gated_o (h_gated),
    .pin_o   (hsync_o)
  );

  dtg_pulse_cond #(.CNT_W(CNT_W)) i_vs (
    .en_i    (ctrl_en),
    .cnt_i   (vcnt),
    .start_i (tim_act[T_VSS]),
    .stop_i  (tim_act[T_VSE]),
    .off_i   (sync_ctl.voff | sync_ctl.all_off),
    .inv_i   (sync_ctl.vinv),
    .gated_o (v_gated),
    .pin_o   (vsync_o)
  );

  assign csync_o   = sync_ctl.sog & (h_gated | v_gated);
  assign in_window = (hcnt <= tim_act[T_HACT]) & (vcnt <= tim_act[T_VACT]);
  assign de_o      = ctrl_en & ctrl_refresh & ~disp_off & in_window;
  assign blank_o   = ~de_o;

  // clamp keeps the strobe inside the line
  assign pf_eff     = (tim_act[T_PF] > tim_act[T_HTOT]) ? tim_act[T_HTOT] : tim_act[T_PF];
  assign prefetch_o = ctrl_en & ctrl_refresh & (hcnt == pf_eff);

  assign hcount_o = hcnt;
  assign vcount_o = vcnt;
endmodule

// File: rtl/dtg_checks.sv
module dtg_checks #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             all_off_i,
  input logic             hinv_i,
  input logic             disp_off_i,
  input logic [CNT_W-1:0] hact_i,
  input logic [CNT_W-1:0] hcount_i,
  input logic [CNT_W-1:0] vcount_i,
  input logic             de_i,
  input logic             hsync_i,
  input logic             prefetch_i
);
  assert_hstep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcount_i != '0) |-> (hcount_i == CNT_W'($past(hcount_i) + 1'b1)));

  assert_vstep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vcount_i) |-> (hcount_i == '0));

  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (hcount_i == '0 && vcount_i == '0));

  assert_de_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |-> (hcount_i <= hact_i));

  assert_alloff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_off_i |-> (hsync_i == hinv_i));

  assert_blank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_off_i |-> !de_i);

  assert_pf_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prefetch_i |-> en_i);
endmodule

bind disp_timing_gen dtg_checks #(.CNT_W(CNT_W)) i_dtg_checks (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (ctrl_en),
  .all_off_i  (sync_ctl.all_off),
  .hinv_i     (sync_ctl.hinv),
  .disp_off_i (disp_off),
  .hact_i     (tim_act[1]),
  .hcount_i   (hcount_o),
  .vcount_i   (vcount_o),
  .de_i       (de_o),
  .hsync_i    (hsync_o),
  .prefetch_i (prefetch_o)
);

// File: tb/test_disp_timing_gen.sv
module test_disp_timing_gen;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             hsync, vsync, csync, de, blank, prefetch;
  logic [CNT_W-1:0] hcount, vcount;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  disp_timing_gen #(.CNT_W(CNT_W)) i_disp_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hsync), .vsync_o(vsync), .csync_o(csync),
    .de_o(de), .blank_o(blank), .hcount_o(hcount), .vcount_o(vcount),
    .prefetch_o(prefetch)
  );

  // behavioural reference: pending and live copies of the nine timing values
  int m_h, m_v, m_ctrl, m_sync, m_disp;
  int pend [9];
  int live [9];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_ctrl = 0; m_sync = 0; m_disp = 0;
      for (int i = 0; i < 9; i++) begin pend[i] = 0; live[i] = 0; end
    end else begin
      int nh, nv;
      bit en, at_frame_end;
      en = m_ctrl[0];
      at_frame_end = en && (m_h == live[0]) && (m_v == live[4]);
      if (!en) begin nh = 0; nv = 0; end
      else if (m_h == live[0]) begin nh = 0; nv = (m_v == live[4]) ? 0 : m_v + 1; end
      else begin nh = m_h + 1; nv = m_v; end
      if (!en || at_frame_end) for (int i = 0; i < 9; i++) live[i] = pend[i];
      if (wr_en) begin
        if (wr_addr == 0) m_ctrl = int'(wr_data);
        else if (wr_addr == 1) m_sync = int'(wr_data);
        else if (wr_addr == 2) m_disp = int'(wr_data);
        else if (wr_addr >= 4 && wr_addr <= 12) pend[wr_addr - 4] = int'(wr_data);
      end
      m_h = nh; m_v = nv;
    end
  end

  task automatic cmp(input string req, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at h=%0d v=%0d t=%0t",
               req, name, act, exp, m_h, m_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit en, ref_on, hp, vp, hg, vg, e_de, e_pf;
      int pf;
      en     = m_ctrl[0];
      ref_on = m_ctrl[1];
      hp = en && m_h >= live[2] && m_h < live[3];
      vp = en && m_v >= live[6] && m_v < live[7];
      hg = hp && !m_sync[5] && !m_sync[1];
      vg = vp && !m_sync[6] && !m_sync[1];
      e_de = en && ref_on && !m_disp[1] && m_h <= live[1] && m_v <= live[5];
      pf = (live[8] > live[0]) ? live[0] : live[8];
      e_pf = en && ref_on && (m_h == pf);
      cmp("R3", "hcount", int'(hcount), m_h);
      cmp("R3", "vcount", int'(vcount), m_v);
      cmp("R6", "hsync", int'(hsync), int'(hg ^ m_sync[3]));
      cmp("R6", "vsync", int'(vsync), int'(vg ^ m_sync[4]));
      cmp("R8", "csync", int'(csync), int'(m_sync[0] && (hg || vg)));
      cmp("R4", "de", int'(de), int'(e_de));
      cmp("R9", "blank", int'(blank), int'(!e_de));
      cmp("R10", "prefetch", int'(prefetch), int'(e_pf));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    #12;
    cmp("R1", "hcount_rst", int'(hcount), 0);
    cmp("R1", "de_rst", int'(de), 0);
    cmp("R1", "blank_rst", int'(blank), 1);
    cmp("R1", "hsync_rst", int'(hsync), 0);
    cmp("R1", "prefetch_rst", int'(prefetch), 0);
    @(negedge clk); rst_n = 1'b1;
    // R2/R11: program mode while idle (20 px x 10 lines)
    wr(4, 19); wr(5, 11); wr(6, 13); wr(7, 16);
    wr(8, 9);  wr(9, 5);  wr(10, 6); wr(11, 8); wr(12, 15);
    run(5);
    cmp("R2", "hcount_idle", int'(hcount), 0);
    wr(0, 3);
    run(420);
    // R6: inversions
    wr(1, 8'h18); run(210);
    // R8: composite flag
    wr(1, 8'h01); run(210);
    // R7: individual and global suppression
    wr(1, 8'h21); run(210);
    wr(1, 8'h48); run(210);
    wr(1, 8'h1B); run(210);
    wr(1, 0);
    // R9: display forced off, sync continues
    wr(2, 2); run(210);
    wr(2, 0);
    // R4: refresh off
    wr(0, 1); run(210);
    wr(0, 3);
    // R11: mid-frame change of line total and width
    run(37);
    wr(4, 24); wr(5, 7);
    run(600);
    // R10: prefetch beyond line total is clamped
    wr(12, 100); run(600);
    // R5: sync window at count 0
    wr(6, 0); wr(7, 3); wr(10, 0); wr(11, 2); run(600);
    // R2: disable mid-line
    run(13);
    wr(0, 0); run(20);
    cmp("R2", "vcount_idle", int'(vcount), 0);
    // R11: writes while idle take effect next clock
    wr(4, 9); wr(8, 3); wr(0, 3); run(200);
    finish_run();
  end
endmodule